// File: doc/BRIEF.md
# FFT Stage Sequencer

This block is the control state machine for an in-place radix-2 FFT datapath that completes one butterfly per cycle. It idles until a start request is seen. It then spends one cycle preparing the input addresses and runs log2(N) stages in sequence. After the final stage it raises a one-cycle completion pulse and returns to idle.

Each stage is made of two halves. Each half has N/4 butterfly read cycles. A result is written one cycle after its operands are read. Because of this, the first cycle of a half only reads, and a closing flush cycle only writes. The output address generator is told to re-initialise at the start of every half. One quiet cycle follows each stage, because the banks just written become the source for the next stage. Every stage except the final one uses regular output ordering, and the final stage writes in bit-reversed order.

The outputs are a stage number, a half flag, read and write enables with their cycle parities, address-initialisation strobes and an ordering select. An address generator and the butterfly datapath use them. The arithmetic and the memories are outside this block.

Top module: `fft_seq`

## Requirements
- R1: After reset the block is idle: busy, done, rd_en, wr_en, in_init, out_init and bitrev are 0 and stage is 0.
- R2: start is sampled on the clock edge and only in idle. The cycle after it is seen high in idle is a single setup cycle with in_init=1, busy=1, and no read or write. While idle with start low, nothing changes.
- R3: Stages are numbered 1 to log2(N) on the stage output and run in increasing order. Each stage lasts exactly 2*(N/4+1)+1 cycles.
- R4: A half has N/4 cycles with rd_en=1. The first of them has wr_en=0. The following N/4-1 have wr_en=1. One flush cycle follows with wr_en=1 and rd_en=0.
- R5: rd_odd is 0 on the first read of each half and toggles on every following read of that half.
- R6: wr_odd on each write equals rd_odd of the read in the previous cycle.
- R7: out_init is 1 exactly on the first read cycle of each half. The half output is 0 in the first half of a stage and 1 in the second.
- R8: After the flush cycle of a stage's second half, one cycle with rd_en=0 and wr_en=0 follows before anything else.
- R9: bitrev is 1 during the read and flush cycles of the last stage only.
- R10: After the gap cycle of the last stage, done is 1 for exactly one cycle. The block is then idle. A start that is high during that done cycle or during a run is ignored, so a held start begins the next run one cycle after done falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Run request, sampled in idle |
| busy | output | 1 | High from setup through the done cycle |
| stage | output | $clog2(log2(N)+1) | Current stage, 1..log2(N); 0 outside stages |
| half | output | 1 | 0 = first half, 1 = second half of the stage |
| rd_en | output | 1 | Butterfly operand read this cycle |
| rd_odd | output | 1 | Parity of the current read within its half |
| wr_en | output | 1 | Butterfly result write this cycle |
| wr_odd | output | 1 | Parity of the read whose result is written |
| in_init | output | 1 | Initialise input addresses (setup cycle) |
| out_init | output | 1 | Initialise output addresses (first cycle of a half) |
| bitrev | output | 1 | Bit-reversed output ordering for this cycle |
| done | output | 1 | One-cycle completion pulse |

## Verification
The sequence is compared cycle by cycle against a walk over stages, halves and butterfly slots. That walk gives the expected enables, parities, strobes and ordering on every cycle. A run started by a one-cycle pulse is compared with a run where start is held high throughout. The held case shows whether start leaks in during busy or done, and whether the next run begins exactly one cycle after idle is reached. A long idle stretch with start low separates true sampling from spurious self-starts. Back-to-back runs show that the stage counter and half flag reset cleanly between runs.

// File: rtl/fft_seq.sv
module fft_seq #(
  parameter int N = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  output logic                           busy,
  output logic [$clog2($clog2(N)+1)-1:0] stage,
  output logic                           half,
  output logic                           rd_en,
  output logic                           rd_odd,
  output logic                           wr_en,
  output logic                           wr_odd,
  output logic                           in_init,
  output logic                           out_init,
  output logic                           bitrev,
  output logic                           done
);
  localparam int L  = $clog2(N);
  localparam int Q  = N / 4;
  localparam int SW = $clog2(L + 1);
  localparam int CW = $clog2(Q + 1);
  localparam logic [SW-1:0] LAST  = SW'(L);
  localparam logic [CW-1:0] CLAST = CW'(Q - 1);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_RUN, S_FLUSH, S_GAP, S_DONE} st_t;

  st_t           st;
  logic [SW-1:0] stg;
  logic [CW-1:0] cnt;
  logic          half_q;
  logic          wodd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      stg    <= '0;
      cnt    <= '0;
      half_q <= 1'b0;
      wodd_q <= 1'b0;
    end else begin
      wodd_q <= (st == S_RUN) ? cnt[0] : 1'b0;
      case (st)
        S_IDLE:  if (start) st <= S_SETUP;
        S_SETUP: begin
          st     <= S_RUN;
          stg    <= SW'(1);
          half_q <= 1'b0;
          cnt    <= '0;
        end
        S_RUN: begin
          if (cnt == CLAST) st <= S_FLUSH;
          else cnt <= cnt + 1'b1;
        end
        S_FLUSH: begin
          cnt <= '0;
          if (!half_q) begin
            st     <= S_RUN;
            half_q <= 1'b1;
          end else begin
            st <= S_GAP;
          end
        end
        S_GAP: begin
          half_q <= 1'b0;
          cnt    <= '0;
          if (stg == LAST) begin
            st  <= S_DONE;
            stg <= '0;
          end else begin
            st  <= S_RUN;
            stg <= stg + 1'b1;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy     = (st != S_IDLE);
  assign stage    = stg;
  assign half     = half_q;
  assign rd_en    = (st == S_RUN);
  assign rd_odd   = rd_en & cnt[0];
  assign wr_en    = ((st == S_RUN) && (cnt != '0)) || (st == S_FLUSH);
  assign wr_odd   = wr_en & wodd_q;
  assign in_init  = (st == S_SETUP);
  assign out_init = rd_en && (cnt == '0);
  assign bitrev   = ((st == S_RUN) || (st == S_FLUSH)) && (stg == LAST);
  assign done     = (st == S_DONE);

  a_r2_setup_from_start: assert property (@(posedge clk) disable iff (!rst_n)
    in_init |-> ($past(start) && !$past(busy)));
  a_r4_first_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    out_init |-> (rd_en && !wr_en));
  a_r6_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en));
  a_r6_write_parity: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_odd == $past(rd_odd)));
  a_r5_parity_toggle: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !out_init) |-> (rd_odd != $past(rd_odd)));
  a_r8_gap_after_stage: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && half) |=> (!rd_en && !wr_en));
  a_r9_bitrev_last: assert property (@(posedge clk) disable iff (!rst_n)
    bitrev |-> (stage == LAST));
  a_r10_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!busy && !done));
endmodule

// File: tb/sim_fft_seq.sv
module sim_fft_seq;
  localparam int CLK_P = 10;
  localparam int N = 16;
  localparam int L = 4;
  localparam int Q = N / 4;
  localparam int SW = $clog2(L + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic busy, half, rd_en, rd_odd, wr_en, wr_odd, in_init, out_init, bitrev, done;
  logic [SW-1:0] stage;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  fft_seq #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .stage(stage),
    .half(half), .rd_en(rd_en), .rd_odd(rd_odd), .wr_en(wr_en), .wr_odd(wr_odd),
    .in_init(in_init), .out_init(out_init), .bitrev(bitrev), .done(done)
  );

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(string req);
    chk(req, "busy", busy, 0);
    chk(req, "done", done, 0);
    chk(req, "rd_en", rd_en, 0);
    chk(req, "wr_en", wr_en, 0);
    chk(req, "in_init", in_init, 0);
    chk(req, "stage", stage, 0);
  endtask

  // Called at the negedge of the setup cycle; ends at the negedge of done.
  task automatic check_run();
    chk("R2", "in_init", in_init, 1);
    chk("R2", "busy", busy, 1);
    chk("R2", "rd_en", rd_en, 0);
    chk("R2", "wr_en", wr_en, 0);
    for (int s = 1; s <= L; s++) begin
      for (int h = 0; h < 2; h++) begin
        for (int c = 0; c <= Q; c++) begin
          @(negedge clk);
          chk("R3", "stage", stage, s);
          chk("R7", "half", half, h);
          chk("R9", "bitrev", bitrev, (s == L) ? 1 : 0);
          chk("R2", "in_init", in_init, 0);
          if (c < Q) begin
            chk("R4", "rd_en", rd_en, 1);
            chk("R4", "wr_en", wr_en, (c != 0) ? 1 : 0);
            chk("R5", "rd_odd", rd_odd, c % 2);
            chk("R7", "out_init", out_init, (c == 0) ? 1 : 0);
            if (c != 0) chk("R6", "wr_odd", wr_odd, (c - 1) % 2);
          end else begin
            chk("R4", "flush rd_en", rd_en, 0);
            chk("R4", "flush wr_en", wr_en, 1);
            chk("R6", "flush wr_odd", wr_odd, (Q - 1) % 2);
            chk("R7", "out_init", out_init, 0);
          end
        end
      end
      @(negedge clk);
      chk("R8", "gap rd_en", rd_en, 0);
      chk("R8", "gap wr_en", wr_en, 0);
      chk("R8", "gap bitrev", bitrev, 0);
      chk("R3", "gap stage", stage, s);
      chk("R10", "gap done", done, 0);
    end
    @(negedge clk);
    chk("R10", "done", done, 1);
    chk("R10", "stage", stage, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1");
    chk("R1", "out_init", out_init, 0);
    chk("R1", "bitrev", bitrev, 0);
  endtask

  task automatic t_idle_low();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      chk_idle("R2");
    end
  endtask

  task automatic t_pulse_run();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check_run();
    @(negedge clk);
    chk_idle("R10");
    @(negedge clk);
    chk_idle("R10");
  endtask

  task automatic t_held_start();
    start = 1'b1;
    @(negedge clk);
    check_run();
    @(negedge clk);
    chk_idle("R10");
    @(negedge clk);
    start = 1'b0;
    check_run();
    @(negedge clk);
    chk_idle("R10");
  endtask

  initial begin
    t_reset();
    t_idle_low();
    t_pulse_run();
    t_held_start();
    t_pulse_run();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule